// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines, stores them as pending requests, picks the most urgent one that is not masked, and raises a single interrupt line toward the processor. Input 0 has the highest priority and input 7 the lowest. The processor answers with two acknowledge pulses. The first pulse commits the request to the in-service register. The second pulse presents an 8-bit vector that combines a programmed base with the number of the input.

Software sets the block up through a small write port. It first writes a start word and then two further setup words. After that it can write the mask, a per-input trigger-select register, end-of-interrupt commands and a mode word. A read selector returns the pending, in-service or mask register. Each input is either edge-triggered or level-triggered, chosen by its own bit. A request that disappears during the first acknowledge pulse produces the lowest-priority vector and sets no in-service bit. End-of-interrupt can be issued by software, either for the most urgent in-service level or for a named level. It can also happen automatically when the second acknowledge pulse ends.

Top module: `prio_irq_ctrl`

## Requirements
- R1: With its trigger-select bit at 0, an input raises a request only on a low-to-high change. An input that stays high after its request is acknowledged and its EOI is done raises no further request.
- R2: With its trigger-select bit at 1, an input's pending bit follows the level on the line. A line still high after its EOI raises the interrupt output again. A line that goes low withdraws the request.
- R3: Bit 3 of the start word (address 0) has no effect on trigger mode. Only the trigger-select register (address 4, bit i for input i) sets it.
- R4: If the winning input is low when the first acknowledge pulse ends, the vector carries level 7 and no in-service bit is set.
- R5: EOI command (address 2) with data[7:6]=01 clears the lowest-numbered set in-service bit.
- R6: EOI command with data[7:6]=10 clears the in-service bit whose number is in data[2:0].
- R7: When special mask mode is on (address 3, data[0]=1), a data[7:6]=01 EOI passes over in-service bits whose mask bit is set.
- R8: When bit 1 of the second setup word is 1, the in-service bit set by an acknowledge is cleared again as the second acknowledge pulse ends.
- R9: The interrupt output is high only after setup is complete, and only when an unmasked pending input has a lower number than every set in-service bit. Mask bit i (address 1 after setup) blocks input i.
- R10: The in-service bit of the winner is set when the first acknowledge pulse ends, and an edge-mode pending bit is cleared at the same time. The vector {base[7:3], level} is valid while the second pulse is high. The base is the first setup word (address 1).
- R11: A start-word write clears the mask, the in-service register, special mask mode and the edge detectors. A line that is already high is therefore not seen as an edge. The write then expects the two setup words at address 1, in order.
- R12: The read port returns pending bits for rd_sel=0, in-service bits for rd_sel=1 and the mask for rd_sel=2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 start, 1 setup/mask, 2 EOI, 3 mode, 4 trigger select |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read select: 0 pending, 1 in-service, 2 mask |
| rd_data | output | 8 | Selected register |
| irq_in | input | 8 | Request lines |
| iack | input | 1 | Acknowledge pulse, high while active |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Interrupt vector |
| vec_vld | output | 1 | Vector valid during second acknowledge pulse |

## Verification
A pending or in-service bit left in the wrong state has two visible effects. The interrupt output is wrong within one clock of the stimulus. The vector from the next acknowledge is also wrong. Both are observed through the read port and the vector, so a fault shows no later than the end of the acknowledge that follows it. Trigger-mode faults show when the interrupt output re-rises, or fails to, right after an EOI with the line held high. EOI selection faults show in the in-service read-back on the cycle after the command write.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SETUP_OFF   = 2'd0,
    SETUP_BASE  = 2'd1,
    SETUP_OPTS  = 2'd2,
    SETUP_READY = 2'd3
  } setup_st_t;

  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_FIRST = 2'd1,
    ACK_GAP   = 2'd2,
    ACK_SECND = 2'd3
  } ack_ph_t;

  localparam logic [2:0] A_START = 3'd0;
  localparam logic [2:0] A_SETUP = 3'd1;
  localparam logic [2:0] A_EOI   = 3'd2;
  localparam logic [2:0] A_MODE  = 3'd3;
  localparam logic [2:0] A_TRIG  = 3'd4;

  localparam logic [1:0] EOI_NS   = 2'b01;
  localparam logic [1:0] EOI_SPEC = 2'b10;
endpackage

// File: rtl/pic_lowbit.sv
module pic_lowbit #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [LW-1:0] idx,
  output logic          any,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = LW'(i);
        any = 1'b1;
      end
    end
    onehot = any ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/pic_req_unit.sv
module pic_req_unit #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] trig_lvl,
  input  logic         det_clr,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] line_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar g = 0; g < N; g++) begin : g_in
    always_comb begin
      pend_d[g] = (pend_q[g] & ~ack_clr[g]) | (irq_in[g] & ~line_q[g]);
      irr[g]    = trig_lvl[g] ? line_q[g] : pend_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[g] <= 1'b0;
        pend_q[g] <= 1'b0;
      end else if (det_clr) begin
        line_q[g] <= 1'b1;
        pend_q[g] <= 1'b0;
      end else begin
        line_q[g] <= irq_in[g];
        pend_q[g] <= pend_d[g];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic          iack,
  output logic          int_out,
  output logic [DW-1:0] vec_out,
  output logic          vec_vld
);
  localparam int LW = $clog2(N_IRQ);
  localparam int BW = DW - LW;

  setup_st_t       setup_q, setup_d;
  ack_ph_t         phase_q, phase_d;
  logic [N_IRQ-1:0] mask_q, mask_d, isr_q, isr_d, trig_q, trig_d;
  logic [BW-1:0]   base_q, base_d;
  logic            auto_q, auto_d, smm_q, smm_d;
  logic [LW-1:0]   lvl_q, lvl_d;
  logic            spur_q, spur_d, vld_q, vld_d, iack_q;
  logic [DW-1:0]   vec_q, vec_d;

  logic [N_IRQ-1:0] irr, isr_set, isr_clr, ack_clr, eoi_src, eoi_oh;
  logic [N_IRQ-1:0] win_oh_unused, isr_oh_unused;
  logic [LW-1:0]   win_idx, isr_idx, eoi_idx_unused;
  logic            win_any, isr_any, eoi_any_unused;
  logic            start_wr, ack_rise, ack_fall;

  assign start_wr = wr_en && (wr_addr == A_START);
  assign ack_rise = iack & ~iack_q;
  assign ack_fall = ~iack & iack_q;
  assign eoi_src  = smm_q ? (isr_q & ~mask_q) : isr_q;

  pic_req_unit #(.N(N_IRQ)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_lvl(trig_q),
    .det_clr(start_wr), .ack_clr(ack_clr), .irr(irr)
  );

  pic_lowbit #(.N(N_IRQ), .LW(LW)) u_win (
    .vec(irr & ~mask_q), .idx(win_idx), .any(win_any), .onehot(win_oh_unused)
  );

  pic_lowbit #(.N(N_IRQ), .LW(LW)) u_top (
    .vec(isr_q), .idx(isr_idx), .any(isr_any), .onehot(isr_oh_unused)
  );

  pic_lowbit #(.N(N_IRQ), .LW(LW)) u_eoi (
    .vec(eoi_src), .idx(eoi_idx_unused), .any(eoi_any_unused), .onehot(eoi_oh)
  );

  assign int_out = (setup_q == SETUP_READY) && win_any &&
                   (!isr_any || (win_idx < isr_idx));

  always_comb begin
    setup_d = setup_q;
    phase_d = phase_q;
    mask_d  = mask_q;
    trig_d  = trig_q;
    base_d  = base_q;
    auto_d  = auto_q;
    smm_d   = smm_q;
    lvl_d   = lvl_q;
    spur_d  = spur_q;
    vld_d   = vld_q;
    vec_d   = vec_q;
    isr_set = '0;
    isr_clr = '0;
    ack_clr = '0;

    unique case (phase_q)
      ACK_IDLE: if (ack_rise) begin
        phase_d = ACK_FIRST;
        lvl_d   = win_any ? win_idx : '1;
        spur_d  = !win_any;
      end
      ACK_FIRST: if (ack_fall) begin
        phase_d = ACK_GAP;
        if (spur_q || !irq_in[lvl_q]) begin
          lvl_d  = '1;
          spur_d = 1'b1;
        end else begin
          isr_set[lvl_q] = 1'b1;
          ack_clr[lvl_q] = 1'b1;
        end
      end
      ACK_GAP: if (ack_rise) begin
        phase_d = ACK_SECND;
        vec_d   = {base_q, lvl_q};
        vld_d   = 1'b1;
      end
      ACK_SECND: if (ack_fall) begin
        phase_d = ACK_IDLE;
        vld_d   = 1'b0;
        if (auto_q && !spur_q) isr_clr = isr_clr | eoi_oh;
      end
      default: phase_d = ACK_IDLE;
    endcase

    if (wr_en) begin
      unique case (wr_addr)
        A_SETUP: begin
          unique case (setup_q)
            SETUP_BASE:  begin base_d = wr_data[DW-1:LW]; setup_d = SETUP_OPTS; end
            SETUP_OPTS:  begin auto_d = wr_data[1]; setup_d = SETUP_READY; end
            SETUP_READY: mask_d = wr_data[N_IRQ-1:0];
            default:     setup_d = setup_q;
          endcase
        end
        A_EOI: begin
          if (wr_data[7:6] == EOI_NS)   isr_clr = isr_clr | eoi_oh;
          if (wr_data[7:6] == EOI_SPEC) isr_clr[wr_data[LW-1:0]] = 1'b1;
        end
        A_MODE:  smm_d  = wr_data[0];
        A_TRIG:  trig_d = wr_data[N_IRQ-1:0];
        default: setup_d = setup_q;
      endcase
    end

    isr_d = (isr_q | isr_set) & ~isr_clr;

    if (start_wr) begin
      setup_d = SETUP_BASE;
      phase_d = ACK_IDLE;
      mask_d  = '0;
      isr_d   = '0;
      smm_d   = 1'b0;
      vld_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= SETUP_OFF;
      phase_q <= ACK_IDLE;
      mask_q  <= '0;
      isr_q   <= '0;
      trig_q  <= '0;
      base_q  <= '0;
      auto_q  <= 1'b0;
      smm_q   <= 1'b0;
      lvl_q   <= '0;
      spur_q  <= 1'b0;
      vld_q   <= 1'b0;
      vec_q   <= '0;
      iack_q  <= 1'b0;
    end else begin
      setup_q <= setup_d;
      phase_q <= phase_d;
      mask_q  <= mask_d;
      isr_q   <= isr_d;
      trig_q  <= trig_d;
      base_q  <= base_d;
      auto_q  <= auto_d;
      smm_q   <= smm_d;
      lvl_q   <= lvl_d;
      spur_q  <= spur_d;
      vld_q   <= vld_d;
      vec_q   <= vec_d;
      iack_q  <= iack;
    end
  end

  always_comb begin
    unique case (rd_sel)
      2'd0:    rd_data = DW'(irr);
      2'd1:    rd_data = DW'(isr_q);
      2'd2:    rd_data = DW'(mask_q);
      default: rd_data = '0;
    endcase
  end

  assign vec_out = vec_q;
  assign vec_vld = vld_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_IRQ = 8,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic             iack,
  input logic             iack_q,
  input logic             int_out,
  input logic             vec_vld,
  input logic [DW-1:0]    vec_out,
  input logic [N_IRQ-1:0] irr,
  input logic [N_IRQ-1:0] isr,
  input logic [N_IRQ-1:0] mask
);
  AST_INT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (|(irr & ~mask))); // R9

  AST_ISR_SET_AT_ACK_END: assert property (@(posedge clk) disable iff (!rst_n)
    (|(isr & ~$past(isr))) |-> (!iack_q && $past(iack_q))); // R10

  AST_VLD_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> $past(iack)); // R10

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_vld && $past(vec_vld)) |-> $stable(vec_out)); // R10

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && (wr_addr == '0)) |-> (isr == '0 && mask == '0)); // R11
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_IRQ(N_IRQ), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .iack(iack),
  .iack_q(iack_q), .int_out(int_out), .vec_vld(vec_vld), .vec_out(vec_out),
  .irr(irr), .isr(isr_q), .mask(mask_q)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = 2'd1;
  logic [7:0] rd_data;
  logic [7:0] irq_in = '0;
  logic       iack = 1'b0;
  logic       int_out;
  logic [7:0] vec_out;
  logic       vec_vld;

  int checks = 0;
  int failures = 0;
  logic [7:0] got_vec, isr_mid;
  logic       got_vld;

  always #5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_in(irq_in),
    .iack(iack), .int_out(int_out), .vec_out(vec_out), .vec_vld(vec_vld)
  );

  // {mask, irq lines, expected int, expected level}, all inputs level mode
  localparam logic [19:0] TBL [6] = '{
    {8'h00, 8'h81, 1'b1, 3'd0},
    {8'h01, 8'h81, 1'b1, 3'd7},
    {8'h00, 8'h30, 1'b1, 3'd4},
    {8'hFF, 8'hFF, 1'b0, 3'd0},
    {8'h00, 8'h00, 1'b0, 3'd0},
    {8'h04, 8'h0C, 1'b1, 3'd3}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [7:0] start, input logic [7:0] opts);
    wr(3'd0, start);
    wr(3'd1, 8'h40);
    wr(3'd1, opts);
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s; #1 v = rd_data; rd_sel = 2'd1;
  endtask

  task automatic ack(input logic [7:0] drop);
    rd_sel = 2'd1;
    iack = 1'b1; tick(1);
    iack = 1'b0; irq_in = irq_in & ~drop; tick(1);
    isr_mid = rd_data;
    iack = 1'b1; tick(1);
    got_vec = vec_out; got_vld = vec_vld;
    iack = 1'b0; tick(1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [7:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // reset state
    chk("R11 int after reset", int_out, 0);
    chk("R10 vld after reset", vec_vld, 0);
    rd(2'd1, v); chk("R12 isr after reset", v, 8'h00);
    rd(2'd2, v); chk("R12 mask after reset", v, 8'h00);

    // table: priority and masking in level mode
    for (int k = 0; k < 6; k++) begin
      setup(8'h10, 8'h00);
      wr(3'd4, 8'hFF);
      wr(3'd1, TBL[k][19:12]);
      irq_in = TBL[k][11:4];
      tick(2);
      chk("R9 int from table", int_out, TBL[k][3]);
      if (TBL[k][3]) begin
        ack(8'h00);
        chk("R10 table vector", got_vec, {5'b01000, TBL[k][2:0]});
        irq_in = '0;
        wr(3'd2, 8'h40);
        rd(2'd1, v); chk("R5 table isr cleared", v, 8'h00);
      end
      irq_in = '0;
      tick(1);
    end

    // R1/R3: edge mode with start-word bit 3 set
    wr(3'd4, 8'h00);
    setup(8'h18, 8'h00);
    irq_in = 8'h04; tick(2);
    chk("R1 edge raises int", int_out, 1);
    rd(2'd0, v); chk("R12 irr edge pending", v, 8'h04);
    ack(8'h00);
    chk("R10 edge vector", got_vec, 8'h42);
    chk("R10 vld in second pulse", got_vld, 1);
    rd(2'd0, v); chk("R10 edge pending cleared", v, 8'h00);
    rd(2'd1, v); chk("R10 isr set", v, 8'h04);
    wr(3'd2, 8'h40); tick(2);
    chk("R3 edge despite bit3, no re-request", int_out, 0);
    chk("R1 high line no new request", int_out, 0);
    irq_in = 8'h00; tick(1);
    irq_in = 8'h04; tick(2);
    chk("R1 new edge raises int", int_out, 1);
    setup(8'h10, 8'h00); tick(2);
    rd(2'd0, v); chk("R11 edge detector cleared", v, 8'h00);
    chk("R11 no int after restart", int_out, 0);
    irq_in = 8'h00; tick(1);

    // R2: level mode re-request
    wr(3'd4, 8'hFF);
    irq_in = 8'h08; tick(2);
    chk("R2 level raises int", int_out, 1);
    ack(8'h00);
    chk("R10 level vector", got_vec, 8'h43);
    tick(1);
    chk("R9 same level blocked", int_out, 0);
    wr(3'd2, 8'h40); tick(1);
    chk("R2 re-request after EOI", int_out, 1);
    irq_in = 8'h00; tick(2);
    chk("R2 drop withdraws", int_out, 0);

    // R4: spurious
    irq_in = 8'h20; tick(2);
    ack(8'h20);
    chk("R4 spurious vector", got_vec, 8'h47);
    rd(2'd1, v); chk("R4 no isr on spurious", v, 8'h00);

    // R5/R6/R7/R9: nesting and EOI kinds
    irq_in = 8'h10; tick(2);
    ack(8'h00); irq_in = 8'h00;
    chk("R10 vector 4", got_vec, 8'h44);
    irq_in = 8'h40; tick(2);
    chk("R9 lower blocked by isr", int_out, 0);
    irq_in = 8'h02; tick(2);
    chk("R9 higher passes isr", int_out, 1);
    ack(8'h00); irq_in = 8'h00;
    rd(2'd1, v); chk("R10 nested isr", v, 8'h12);
    wr(3'd2, 8'h40);
    rd(2'd1, v); chk("R5 non-specific clears lowest", v, 8'h10);
    irq_in = 8'h02; tick(2);
    ack(8'h00); irq_in = 8'h00;
    wr(3'd2, 8'h84);
    rd(2'd1, v); chk("R6 specific clears level 4", v, 8'h02);
    irq_in = 8'h10; tick(2);
    ack(8'h00); irq_in = 8'h00;
    wr(3'd1, 8'h02); wr(3'd3, 8'h01);
    wr(3'd2, 8'h40);
    rd(2'd1, v); chk("R7 special mask skips bit1", v, 8'h02);
    wr(3'd3, 8'h00); wr(3'd1, 8'h00);
    wr(3'd2, 8'h40);
    rd(2'd1, v); chk("R5 final clear", v, 8'h00);

    // R8: automatic EOI
    setup(8'h10, 8'h02);
    wr(3'd4, 8'hFF);
    irq_in = 8'h40; tick(2);
    ack(8'h00); irq_in = 8'h00;
    chk("R10 isr between pulses", isr_mid, 8'h40);
    chk("R8 vector", got_vec, 8'h46);
    rd(2'd1, v); chk("R8 auto cleared", v, 8'h00);

    // R11/R12: start word clears mask and isr; int waits for setup
    wr(3'd1, 8'hAA);
    rd(2'd2, v); chk("R12 mask readback", v, 8'hAA);
    irq_in = 8'h01; tick(2);
    ack(8'h00);
    rd(2'd1, v); chk("R8 auto clears again", v, 8'h00);
    irq_in = 8'h00; tick(1);
    setup(8'h10, 8'h00);
    irq_in = 8'h01; tick(2);
    ack(8'h00); irq_in = 8'h00;
    rd(2'd1, v); chk("R10 isr before restart", v, 8'h01);
    wr(3'd1, 8'hAA);
    irq_in = 8'h01;
    wr(3'd0, 8'h10); tick(2);
    rd(2'd2, v); chk("R11 mask cleared", v, 8'h00);
    rd(2'd1, v); chk("R11 isr cleared", v, 8'h00);
    chk("R11 int held during setup", int_out, 0);
    wr(3'd1, 8'h40); wr(3'd1, 8'h00); tick(1);
    chk("R11 int after setup", int_out, 1);
    irq_in = 8'h00; tick(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule